// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Read Pipeline

This block is a synthesizable behavioural model of a clocked static RAM. Its word is split into byte lanes, four lanes of nine bits by default. Every control except output enable and sleep is sampled on the rising clock edge. An access either starts at a supplied address or continues a short burst. In a burst, a two-bit counter steps the low address bits in linear order (with wrap) or in interleaved order (XOR with the start offset). The order is chosen at run time.

Read data leaves the block in one of two ways, chosen by a run-time input. In flow-through mode it comes straight from the array, so it is valid right after the address edge. In pipelined mode it passes through an output register first, which adds one edge. A deselect reaches the output stage in the same number of edges as the data path, so the outputs switch off without an extra hold cycle.

Output enable and sleep both gate the outputs without a clock. Sleep also freezes the array contents and makes the block ignore its synchronous inputs. The bidirectional data bus is modelled as a separate input word, output word and output-valid flag.

Top module: `sync_burst_sram`

## Requirements
- R1: While and after reset (rst_n low), dout_en is 0 and dout is all zeros until a read is issued.
- R2: With pipe_en=0, a read registered at edge N presents the word on dout, with dout_en=1, right after edge N.
- R3: With pipe_en=1, a read registered at edge N leaves dout_en at 0 after edge N and presents the word after edge N+1.
- R4: A cycle with neither strobe low continues the current access. With adv_n=0 the 2-bit offset counter steps. For order_linear=1 the low two address bits are (start+count) mod 4, so a start of 2 gives 2,3,0,1. For order_linear=0 they are start XOR count, so a start of 1 gives 1,0,3,2. With adv_n=1 the address is held.
- R5: wr_all_n=0 on a write-capable access writes all four lanes, whatever wr_byte_n and lane_sel_n are.
- R6: With wr_all_n=1 and wr_byte_n=0, only lane i with lane_sel_n[i]=0 is written. Lane i is din[9i+8:9i], so lane 0 is the least significant. With wr_byte_n=1, or with no lane selected, the access is a read.
- R7: An access started with start_rd_n=0 is always a read, even when the write controls are active.
- R8: The block is selected only when sel_n=0 and sel=1. A strobe while not selected is a deselect. Continuation cycles after a deselect neither read nor write.
- R9: After a deselect or write edge, dout_en drops right after that edge in flow-through mode, and one edge later in pipelined mode.
- R10: oe_n=1 forces dout_en to 0 and dout to zero with no clock edge. Returning oe_n to 0 restores the output at once.
- R11: sleep=1 forces dout_en to 0 at once. Clock edges while asleep write nothing, and the array contents are kept. The block returns deselected, and the first edge after sleep falls acts normally.
- R12: A word written at edge N is returned by a read of the same address registered at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| addr | input | ADDR_W | Start address for a strobed access |
| start_rd_n | input | 1 | Strobe starting an access that always reads, active low |
| start_n | input | 1 | Strobe starting a read or write access, active low |
| adv_n | input | 1 | Step burst counter on continuation cycles, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_byte_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| pipe_en | input | 1 | 1 = registered read path, 0 = flow-through |
| order_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench walks byte-select patterns, each on a freshly filled word. A lane-mask slip, a reversed lane order or a missing global override would leave the wrong nine-bit fields set. It measures read latency and output turn-off edge by edge in both read modes. A path with one register too many or too few would show data or dout_en an edge early or late, and a double-stage deselect would hold the bus for one extra cycle. It runs bursts that wrap in both orders, where an adder in place of an XOR, or a missing wrap, returns the wrong word. It also tries writes through the read-only strobe, while deselected and while asleep; a design that let any of them through would corrupt the word read back afterwards.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
   // number of address bits driven by the burst counter
   localparam int unsigned BURST_W = 2;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;
endpackage

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen #(
   parameter int unsigned AW = 6,
   parameter int unsigned CW = sram_pkg::BURST_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          load,
   input  logic          step,
   input  logic          order_linear,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] cur_addr
);
   logic [AW-1:0] base_q, base_sel;
   logic [CW-1:0] cnt_q, cnt_nx, offs;

   generate
      if (CW >= AW) begin : g_bad_cw
         $error("burst counter must be narrower than the address");
      end
   endgenerate

   always_comb begin
      base_sel = load ? addr_in : base_q;
      cnt_nx   = load ? '0 : cnt_q + CW'(step);
      if (order_linear == sram_pkg::ORD_LINEAR)
         offs = base_sel[CW-1:0] + cnt_nx;
      else
         offs = base_sel[CW-1:0] ^ cnt_nx;
      cur_addr = {base_sel[AW-1:CW], offs};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (upd) begin
         base_q <= base_sel;
         cnt_q  <= cnt_nx;
      end
   end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             sel_n,
   input  logic             sel,
   input  logic             start_rd_n,
   input  logic             start_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic             load,
   output logic             step,
   output logic             upd,
   output logic             rd,
   output logic [LANES-1:0] lane_we
);
   logic active_q, active_nx;
   logic selected, strobe, cont, wr_ok;

   always_comb begin
      selected = ~sel_n & sel;
      strobe   = ~start_rd_n | ~start_n;
      load     = ~sleep & strobe & selected;
      cont     = ~sleep & ~strobe & active_q;
      upd      = load | cont;
      step     = cont & ~adv_n;
      // the read-only strobe never writes
      wr_ok    = upd & start_rd_n;
      if (sleep)       active_nx = 1'b0;
      else if (strobe) active_nx = selected;
      else             active_nx = active_q;
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_we
         assign lane_we[g] = wr_ok & (~wr_all_n | (~wr_byte_n & ~lane_sel_n[g]));
      end
   endgenerate

   assign rd = upd & ~(|lane_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_nx;
   end
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
   parameter int unsigned AW    = 6,
   parameter int unsigned LANES = 4,
   parameter int unsigned LW    = 9
) (
   input  logic                clk,
   input  logic [LANES-1:0]    lane_we,
   input  logic [AW-1:0]       waddr,
   input  logic [LANES*LW-1:0] wdata,
   input  logic [AW-1:0]       raddr,
   output logic [LANES*LW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LW-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (lane_we[g]) mem[waddr] <= wdata[g*LW +: LW];
         end
         assign rdata[g*LW +: LW] = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/sram_read_path.sv
`timescale 1ns/1ps
module sram_read_path #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep,
   input  logic          rd,
   input  logic [AW-1:0] raddr_in,
   input  logic          pipe_en,
   input  logic          oe_n,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr_q,
   output logic [DW-1:0] dout,
   output logic          dout_en
);
   logic          rv_q, pv_q, valid_sel;
   logic [DW-1:0] pdata_q, data_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q    <= 1'b0;
         pv_q    <= 1'b0;
         raddr_q <= '0;
         pdata_q <= '0;
      end else if (sleep) begin
         rv_q <= 1'b0;
         pv_q <= 1'b0;
      end else begin
         rv_q <= rd;
         pv_q <= rv_q;
         if (rd)   raddr_q <= raddr_in;
         if (rv_q) pdata_q <= rdata;
      end
   end

   always_comb begin
      valid_sel = pipe_en ? pv_q : rv_q;
      data_sel  = pipe_en ? pdata_q : rdata;
      dout_en   = valid_sel & ~oe_n & ~sleep;
      dout      = dout_en ? data_sel : '0;
   end
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_n,
   input  logic                     sel,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     start_rd_n,
   input  logic                     start_n,
   input  logic                     adv_n,
   input  logic                     wr_all_n,
   input  logic                     wr_byte_n,
   input  logic [LANES-1:0]         lane_sel_n,
   input  logic                     oe_n,
   input  logic                     sleep,
   input  logic                     pipe_en,
   input  logic                     order_linear,
   input  logic [LANES*LANE_W-1:0]  din,
   output logic [LANES*LANE_W-1:0]  dout,
   output logic                     dout_en
);
   localparam int unsigned DW = LANES * LANE_W;

   generate
      if (LANES < 1 || LANE_W < 1) begin : g_bad_word
         $error("lane count and lane width must be positive");
      end
      if (ADDR_W <= sram_pkg::BURST_W) begin : g_bad_addr
         $error("address must be wider than the burst counter");
      end
   endgenerate

   logic              load, step, upd, rd;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] cur_addr, raddr_q;
   logic [DW-1:0]     rdata;

   sram_ctrl #(.LANES(LANES)) u_ctrl (
      .clk, .rst_n, .sleep, .sel_n, .sel, .start_rd_n, .start_n, .adv_n,
      .wr_all_n, .wr_byte_n, .lane_sel_n,
      .load, .step, .upd, .rd, .lane_we
   );

   burst_addr_gen #(.AW(ADDR_W), .CW(sram_pkg::BURST_W)) u_addr (
      .clk, .rst_n, .upd, .load, .step, .order_linear,
      .addr_in(addr), .cur_addr
   );

   sram_lane_array #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_array (
      .clk, .lane_we, .waddr(cur_addr), .wdata(din),
      .raddr(raddr_q), .rdata
   );

   sram_read_path #(.AW(ADDR_W), .DW(DW)) u_rpath (
      .clk, .rst_n, .sleep, .rd, .raddr_in(cur_addr), .pipe_en, .oe_n,
      .rdata, .raddr_q, .dout, .dout_en
   );
endmodule

// File: rtl/sram_chk.sv
`timescale 1ns/1ps
module sram_chk #(
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_n,
   input logic             sel,
   input logic             start_rd_n,
   input logic             start_n,
   input logic             wr_all_n,
   input logic             wr_byte_n,
   input logic [LANES-1:0] lane_sel_n,
   input logic             oe_n,
   input logic             sleep,
   input logic             pipe_en,
   input logic             dout_en,
   input logic [LANES-1:0] lane_we
);
   logic desel_cmd, desel_d, sel_wr_start;

   assign desel_cmd    = (~start_rd_n | ~start_n) & ~(~sel_n & sel) & ~sleep;
   assign sel_wr_start = ~start_n & start_rd_n & ~sel_n & sel & ~sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) desel_d <= 1'b0;
      else        desel_d <= desel_cmd;
   end

   assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);
   assert_sleep_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_en);
   assert_sleep_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0));
   assert_rdstrobe_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_rd_n && !sleep) |-> (lane_we == '0));
   assert_global_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr_start && !wr_all_n) |-> (&lane_we));
   assert_byte_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr_start && wr_all_n) |-> (lane_we == (wr_byte_n ? '0 : ~lane_sel_n)));
   assert_flow_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (desel_cmd && !pipe_en) |=> (pipe_en || !dout_en));
   assert_pipe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (desel_d && pipe_en) |=> (!pipe_en || !dout_en));
endmodule

bind sync_burst_sram sram_chk #(.LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel),
   .start_rd_n(start_rd_n), .start_n(start_n), .wr_all_n(wr_all_n),
   .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n), .oe_n(oe_n),
   .sleep(sleep), .pipe_en(pipe_en), .dout_en(dout_en), .lane_we(lane_we)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
   localparam int AW = 6;
   localparam int DW = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n, sel, start_rd_n, start_n, adv_n, wr_all_n, wr_byte_n;
   logic oe_n, sleep, pipe_en, order_linear, dout_en;
   logic [3:0]    lane_sel_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sync_burst_sram dut (
      .clk, .rst_n, .sel_n, .sel, .addr, .start_rd_n, .start_n, .adv_n,
      .wr_all_n, .wr_byte_n, .lane_sel_n, .oe_n, .sleep, .pipe_en,
      .order_linear, .din, .dout, .dout_en
   );

   typedef struct packed {
      logic [AW-1:0] a;
      logic          gw;
      logic          bw;
      logic [3:0]    bs;
      logic [DW-1:0] d;
      logic [DW-1:0] exp;
   } vec_t;

   localparam logic [DW-1:0] FILL = 36'hF_FFFF_FFFF;
   localparam vec_t VECS [0:7] = '{
      '{6'd8,  1'b0, 1'b1, 4'b1111, 36'h1_2345_6789, 36'h1_2345_6789},
      '{6'd9,  1'b0, 1'b0, 4'b1110, 36'h0_AAAA_AAAA, 36'h0_AAAA_AAAA},
      '{6'd10, 1'b1, 1'b0, 4'b1110, 36'h0,           36'hF_FFFF_FE00},
      '{6'd11, 1'b1, 1'b0, 4'b0111, 36'h0,           36'h0_07FF_FFFF},
      '{6'd12, 1'b1, 1'b0, 4'b1010, 36'h0,           36'hF_F803_FE00},
      '{6'd13, 1'b1, 1'b1, 4'b0000, 36'h0,           36'hF_FFFF_FFFF},
      '{6'd14, 1'b1, 1'b0, 4'b1111, 36'h0,           36'hF_FFFF_FFFF},
      '{6'd15, 1'b1, 1'b0, 4'b0000, 36'h5_A5A5_A5A5, 36'h5_A5A5_A5A5}
   };

   function automatic logic [DW-1:0] pat(int w);
      return {4{9'(w)}};
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   task automatic idle;
      start_rd_n = 1'b1; start_n = 1'b1; adv_n = 1'b1;
      wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
      sel_n = 1'b0; sel = 1'b1;
   endtask

   task automatic wr(logic [AW-1:0] a, logic gw, logic bw, logic [3:0] bs, logic [DW-1:0] d);
      idle;
      start_n = 1'b0; addr = a; wr_all_n = gw; wr_byte_n = bw; lane_sel_n = bs; din = d;
      tick;
      idle;
   endtask

   task automatic rd(logic [AW-1:0] a);
      idle;
      start_n = 1'b0; addr = a;
      tick;
      idle;
   endtask

   task automatic desel;
      idle;
      start_n = 1'b0; sel_n = 1'b1;
      tick;
      idle;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle;
      addr = '0; din = '0; oe_n = 1'b0; sleep = 1'b0; pipe_en = 1'b0; order_linear = 1'b1;
      repeat (3) tick;
      chk("R1 dout_en in reset", 36'(dout_en), 36'd0);
      rst_n = 1'b1;
      tick;
      chk("R1 dout_en after reset", 36'(dout_en), 36'd0);
      chk("R1 dout after reset", dout, 36'd0);

      // table of lane-write patterns, each on a word first filled with ones
      for (int i = 0; i < 8; i++) begin
         wr(VECS[i].a, 1'b0, 1'b1, 4'hF, FILL);
         wr(VECS[i].a, VECS[i].gw, VECS[i].bw, VECS[i].bs, VECS[i].d);
         if (i == 0) chk("R9 flow off after write", 36'(dout_en), 36'd0);
         rd(VECS[i].a);
         if (i == 7) chk("R12 write then read next cycle", dout, VECS[i].exp);
         else if (i < 2) chk("R5 global write lanes", dout, VECS[i].exp);
         else chk("R6 byte write lanes", dout, VECS[i].exp);
         chk("R2 flow valid after address edge", 36'(dout_en), 36'd1);
      end

      rd(6'd8);
      chk("R2 flow-through data", dout, 36'h1_2345_6789);

      // pipelined latency and deselect timing
      pipe_en = 1'b1;
      desel;
      tick;
      rd(6'd9);
      chk("R3 pipelined not yet valid", 36'(dout_en), 36'd0);
      tick;
      chk("R3 pipelined data", dout, 36'h0_AAAA_AAAA);
      chk("R3 pipelined valid", 36'(dout_en), 36'd1);
      desel;
      chk("R9 pipelined still driving", 36'(dout_en), 36'd1);
      tick;
      chk("R9 pipelined off", 36'(dout_en), 36'd0);
      pipe_en = 1'b0;
      tick;

      rd(6'd8);
      chk("R9 flow driving before deselect", 36'(dout_en), 36'd1);
      desel;
      chk("R9 flow off after deselect", 36'(dout_en), 36'd0);

      // bursts
      for (int k = 0; k < 4; k++) wr(6'(16 + k), 1'b0, 1'b1, 4'hF, pat(16 + k));
      order_linear = 1'b1;
      rd(6'd18);
      chk("R4 linear start", dout, pat(18));
      adv_n = 1'b0;
      tick; chk("R4 linear step1", dout, pat(19));
      tick; chk("R4 linear wrap", dout, pat(16));
      tick; chk("R4 linear step3", dout, pat(17));
      tick; chk("R4 linear back to start", dout, pat(18));
      adv_n = 1'b1;
      tick; chk("R4 hold without advance", dout, pat(18));
      order_linear = 1'b0;
      rd(6'd17);
      chk("R4 interleave start", dout, pat(17));
      adv_n = 1'b0;
      tick; chk("R4 interleave step1", dout, pat(16));
      tick; chk("R4 interleave step2", dout, pat(19));
      tick; chk("R4 interleave step3", dout, pat(18));
      adv_n = 1'b1;
      order_linear = 1'b1;

      // read-only strobe ignores write controls
      idle;
      start_rd_n = 1'b0; addr = 6'd16; wr_all_n = 1'b0; din = '0;
      tick;
      idle;
      chk("R7 read strobe returns data", dout, pat(16));
      rd(6'd16);
      chk("R7 word unchanged", dout, pat(16));

      // chip selects
      idle;
      start_n = 1'b0; sel = 1'b0; addr = 6'd16; wr_all_n = 1'b0; din = '0;
      tick;
      chk("R8 deselected no output", 36'(dout_en), 36'd0);
      start_n = 1'b1; sel = 1'b1;
      tick; tick;
      chk("R8 continuation after deselect idle", 36'(dout_en), 36'd0);
      idle;
      rd(6'd16);
      chk("R8 no write while deselected", dout, pat(16));
      idle;
      start_n = 1'b0; sel_n = 1'b1; addr = 6'd17; wr_all_n = 1'b0; din = '0;
      tick;
      idle;
      rd(6'd17);
      chk("R8 low-active select also needed", dout, pat(17));

      // asynchronous output enable
      rd(6'd18);
      chk("R10 driving", 36'(dout_en), 36'd1);
      oe_n = 1'b1;
      #1;
      chk("R10 oe_n high disables", 36'(dout_en), 36'd0);
      chk("R10 oe_n high zero data", dout, 36'd0);
      oe_n = 1'b0;
      #1;
      chk("R10 oe_n low restores", dout, pat(18));

      // sleep
      sleep = 1'b1;
      #1;
      chk("R11 sleep disables at once", 36'(dout_en), 36'd0);
      idle;
      start_n = 1'b0; addr = 6'd18; wr_all_n = 1'b0; din = '0;
      tick; tick;
      idle;
      sleep = 1'b0;
      tick;
      chk("R11 returns deselected", 36'(dout_en), 36'd0);
      rd(6'd18);
      chk("R11 contents kept, writes ignored", dout, pat(18));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule